// File: doc/BRIEF.md
# Inhibited Position Latch Bus Reader

This block connects two 32-bit axis position counters to an 8-bit host bus. For each axis a 32-bit snapshot register copies its counter on every rising clock edge. A host reads a snapshot one byte at a time, so the snapshot must not move in the middle of a read. To prevent that, a freeze flag is sampled from the bus-control inputs on the falling clock edge. While the flag is set, the snapshot registers stop loading.

A read begins when output-enable is low and the select bits choose the most significant byte. At the next falling edge both axes freeze together, so the X and Y snapshots come from the same cycle. The host then steps through the remaining three bytes and may switch between axes. It ends the read by raising output-enable. The falling edge that sees it high releases the freeze, and the following rising edge loads fresh counter values.

The bus is modelled as an 8-bit data output plus a drive-enable flag. The data output reads zero whenever the bus is not driven. Each axis has its own active-low asynchronous reset. That reset clears the axis snapshot and its freeze flag and leaves the other axis untouched.

Top module: `pos_latch_reader`

## Requirements
- R1: While an axis is not frozen, its snapshot takes the value its counter input had at a rising clock edge. The new value is readable after that edge.
- R2: When the falling edge samples oe_ni low with (sel1_i,sel2_i) = (0,1), both axes freeze. Neither snapshot changes at the following rising edges.
- R3: While oe_ni stays low, the freeze holds whatever the select and axis inputs do.
- R4: A falling edge that samples oe_ni high clears the freeze. The following rising edge reloads the snapshot from the counter.
- R5: If the bus is enabled with a select other than (0,1) while no freeze is active, no freeze is set and the snapshots keep tracking.
- R6: The byte driven is chosen by (sel1_i,sel2_i): (0,1) gives bits 31:24, (1,1) bits 23:16, (0,0) bits 15:8, and (1,0) bits 7:0.
- R7: axis_sel_i = 0 reads the X snapshot and axis_sel_i = 1 reads the Y snapshot.
- R8: data_oe_o equals the inverse of oe_ni, and data_o is zero whenever data_oe_o is low.
- R9: Driving rst_x_ni or rst_y_ni low clears that axis's snapshot to zero and its freeze at once. The other axis keeps its snapshot and its freeze.
- R10: A freeze always applies to both axes together, so a four-byte read of either axis comes from the same capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; snapshots load on rising edges, control is sampled on falling edges |
| rst_x_ni | input | 1 | Active-low asynchronous reset, X axis |
| rst_y_ni | input | 1 | Active-low asynchronous reset, Y axis |
| oe_ni | input | 1 | Active-low bus output enable |
| sel1_i | input | 1 | Byte select bit 1 |
| sel2_i | input | 1 | Byte select bit 2 |
| axis_sel_i | input | 1 | Axis select: 0 = X, 1 = Y |
| cnt_x_i | input | 32 | X axis counter value |
| cnt_y_i | input | 32 | Y axis counter value |
| data_o | output | 8 | Selected snapshot byte, zero when not driven |
| data_oe_o | output | 1 | High when the bus is driven |

## Verification
The assertions assume that the bus-control and counter inputs change only away from both clock edges. They also assume that an axis reset, once asserted, stays low across at least one rising edge. Under these conditions the edge-sampled control and the reset-cleared state never meet within a single clock phase. The bench drives every input one time unit after a rising edge. It holds each random reset pulse from the middle of one cycle until after the next rising edge. The control inputs are random, including reads in and out of order and axis switches in the middle of a read.

// File: rtl/pl_pkg.sv
package pl_pkg;
  typedef enum logic [1:0] {
    BYTE_B0 = 2'd0,
    BYTE_B1 = 2'd1,
    BYTE_B2 = 2'd2,
    BYTE_B3 = 2'd3
  } byte_idx_e;

  // (sel1,sel2): (0,1)->B3, (1,1)->B2, (0,0)->B1, (1,0)->B0
  function automatic byte_idx_e sel_to_idx(input logic sel1, input logic sel2);
    return byte_idx_e'({sel2, ~sel1});
  endfunction

  function automatic logic is_start_sel(input logic sel1, input logic sel2);
    return sel_to_idx(sel1, sel2) == BYTE_B3;
  endfunction
endpackage

// File: rtl/pl_inhibit.sv
module pl_inhibit #(
  parameter int N_AXES = 2
) (
  input  logic              clk_i,
  input  logic [N_AXES-1:0] rst_ni,
  input  logic              oe_ni,
  input  logic              sel1_i,
  input  logic              sel2_i,
  output logic [N_AXES-1:0] inh_o
);
  import pl_pkg::*;

  logic start_rd;
  assign start_rd = !oe_ni && is_start_sel(sel1_i, sel2_i);

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    logic rst_n_a;
    logic inh_q;
    assign rst_n_a = rst_ni[a];

    always_ff @(negedge clk_i or negedge rst_n_a) begin
      if (!rst_n_a)      inh_q <= 1'b0;
      else if (oe_ni)    inh_q <= 1'b0;
      else if (start_rd) inh_q <= 1'b1;
    end

    assign inh_o[a] = inh_q;
  end
endmodule

// File: rtl/pl_latch.sv
module pl_latch #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inh_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] lat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_o <= '0;
    else if (!inh_i) lat_o <= cnt_i;
  end
endmodule

// File: rtl/pl_byte_mux.sv
module pl_byte_mux #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 4,
  localparam int CNT_W  = BYTE_W * N_BYTES
) (
  input  logic [CNT_W-1:0]  lat_x_i,
  input  logic [CNT_W-1:0]  lat_y_i,
  input  logic              axis_sel_i,
  input  logic              sel1_i,
  input  logic              sel2_i,
  input  logic              oe_ni,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o
);
  import pl_pkg::*;

  logic [CNT_W-1:0]  lat_sel;
  logic [BYTE_W-1:0] bytes_q [N_BYTES];
  byte_idx_e         idx;

  assign lat_sel = axis_sel_i ? lat_y_i : lat_x_i;
  assign idx     = sel_to_idx(sel1_i, sel2_i);

  for (genvar b = 0; b < N_BYTES; b++) begin : g_slice
    assign bytes_q[b] = lat_sel[b*BYTE_W +: BYTE_W];
  end

  assign data_oe_o = !oe_ni;
  assign data_o    = data_oe_o ? bytes_q[idx] : '0;
endmodule

// File: rtl/pos_latch_reader.sv
module pos_latch_reader #(
  parameter int  BYTE_W = 8,
  localparam int N_BYTES = 4,
  localparam int CNT_W   = BYTE_W * N_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_x_ni,
  input  logic              rst_y_ni,
  input  logic              oe_ni,
  input  logic              sel1_i,
  input  logic              sel2_i,
  input  logic              axis_sel_i,
  input  logic [CNT_W-1:0]  cnt_x_i,
  input  logic [CNT_W-1:0]  cnt_y_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int N_AXES = 2;

  logic [N_AXES-1:0] rst_n_v;
  logic [N_AXES-1:0] inh_q;
  logic [CNT_W-1:0]  cnt_v [N_AXES];
  logic [CNT_W-1:0]  lat_v [N_AXES];
  logic [CNT_W-1:0]  lat_x;
  logic [CNT_W-1:0]  lat_y;

  assign rst_n_v  = {rst_y_ni, rst_x_ni};
  assign cnt_v[0] = cnt_x_i;
  assign cnt_v[1] = cnt_y_i;

  pl_inhibit #(.N_AXES(N_AXES)) u_inh (
    .clk_i  (clk_i),
    .rst_ni (rst_n_v),
    .oe_ni  (oe_ni),
    .sel1_i (sel1_i),
    .sel2_i (sel2_i),
    .inh_o  (inh_q)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_lat
    pl_latch #(.W(CNT_W)) u_lat (
      .clk_i  (clk_i),
      .rst_ni (rst_n_v[a]),
      .inh_i  (inh_q[a]),
      .cnt_i  (cnt_v[a]),
      .lat_o  (lat_v[a])
    );
  end

  assign lat_x = lat_v[0];
  assign lat_y = lat_v[1];

  pl_byte_mux #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_mux (
    .lat_x_i    (lat_x),
    .lat_y_i    (lat_y),
    .axis_sel_i (axis_sel_i),
    .sel1_i     (sel1_i),
    .sel2_i     (sel2_i),
    .oe_ni      (oe_ni),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );
endmodule

// File: rtl/pl_reader_chk.sv
module pl_reader_chk #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_x_ni,
  input logic              rst_y_ni,
  input logic              oe_ni,
  input logic              sel1_i,
  input logic              sel2_i,
  input logic              inh_x,
  input logic              inh_y,
  input logic [CNT_W-1:0]  lat_x,
  input logic [CNT_W-1:0]  lat_y,
  input logic [CNT_W-1:0]  cnt_x_i,
  input logic [CNT_W-1:0]  cnt_y_i,
  input logic [BYTE_W-1:0] data_o,
  input logic              data_oe_o
);
  assert_track_x_R1: assert property (@(posedge clk_i) disable iff (!rst_x_ni)
    !inh_x |=> lat_x == $past(cnt_x_i));
  assert_track_y_R1: assert property (@(posedge clk_i) disable iff (!rst_y_ni)
    !inh_y |=> lat_y == $past(cnt_y_i));

  assert_frozen_x_R2: assert property (@(posedge clk_i) disable iff (!rst_x_ni)
    inh_x |=> $stable(lat_x));
  assert_frozen_y_R2: assert property (@(posedge clk_i) disable iff (!rst_y_ni)
    inh_y |=> $stable(lat_y));

  // R10: a read start freezes both axes at the same falling edge
  assert_start_both_R10: assert property (@(negedge clk_i) disable iff (!rst_x_ni || !rst_y_ni)
    (!oe_ni && !sel1_i && sel2_i) |=> (inh_x && inh_y));

  assert_hold_R3: assert property (@(negedge clk_i) disable iff (!rst_x_ni)
    (!oe_ni && inh_x) |=> inh_x);

  assert_release_R4: assert property (@(negedge clk_i) disable iff (!rst_x_ni || !rst_y_ni)
    oe_ni |=> (!inh_x && !inh_y));

  assert_no_false_start_R5: assert property (@(negedge clk_i) disable iff (!rst_x_ni)
    (!inh_x && !(!oe_ni && !sel1_i && sel2_i)) |=> !inh_x);

  assert_idle_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_x_ni)
    !data_oe_o |-> data_o == '0);
endmodule

bind pos_latch_reader pl_reader_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_x_ni  (rst_x_ni),
  .rst_y_ni  (rst_y_ni),
  .oe_ni     (oe_ni),
  .sel1_i    (sel1_i),
  .sel2_i    (sel2_i),
  .inh_x     (inh_q[0]),
  .inh_y     (inh_q[1]),
  .lat_x     (lat_x),
  .lat_y     (lat_y),
  .cnt_x_i   (cnt_x_i),
  .cnt_y_i   (cnt_y_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o)
);

// File: tb/tb_pos_latch_reader.sv
module tb_pos_latch_reader;
  logic        clk = 1'b0;
  logic        rst_x_n, rst_y_n, oe_n, sel1, sel2, axis_sel;
  logic [31:0] cnt_x, cnt_y;
  logic [7:0]  data;
  logic        data_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pos_latch_reader dut (
    .clk_i(clk), .rst_x_ni(rst_x_n), .rst_y_ni(rst_y_n), .oe_ni(oe_n),
    .sel1_i(sel1), .sel2_i(sel2), .axis_sel_i(axis_sel),
    .cnt_x_i(cnt_x), .cnt_y_i(cnt_y), .data_o(data), .data_oe_o(data_oe)
  );

  // reference model built from R1..R5, R9, R10
  logic [31:0] m_lat_x, m_lat_y;
  logic        m_frz_x, m_frz_y;

  always @(negedge clk or negedge rst_x_n)
    if (!rst_x_n) m_frz_x <= 1'b0;
    else if (oe_n) m_frz_x <= 1'b0;
    else if (!sel1 && sel2) m_frz_x <= 1'b1;

  always @(negedge clk or negedge rst_y_n)
    if (!rst_y_n) m_frz_y <= 1'b0;
    else if (oe_n) m_frz_y <= 1'b0;
    else if (!sel1 && sel2) m_frz_y <= 1'b1;

  always @(posedge clk or negedge rst_x_n)
    if (!rst_x_n) m_lat_x <= '0;
    else if (!m_frz_x) m_lat_x <= cnt_x;

  always @(posedge clk or negedge rst_y_n)
    if (!rst_y_n) m_lat_y <= '0;
    else if (!m_frz_y) m_lat_y <= cnt_y;

  // R6 byte encoding
  function automatic logic [7:0] pick(input logic [31:0] v, input logic s1, input logic s2);
    case ({s1, s2})
      2'b01:   return v[31:24];
      2'b11:   return v[23:16];
      2'b00:   return v[15:8];
      default: return v[7:0];
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic oe, input logic s1, input logic s2, input logic ax,
                     input logic [31:0] cx, input logic [31:0] cy);
    @(posedge clk);
    #1;
    oe_n = oe; sel1 = s1; sel2 = s2; axis_sel = ax; cnt_x = cx; cnt_y = cy;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_x_n = 0; rst_y_n = 0; oe_n = 0; sel1 = 0; sel2 = 1; axis_sel = 0;
    cnt_x = 32'hFFFF_FFFF; cnt_y = 32'hFFFF_FFFF;
    #3;
    chk("R9 reset x", data, 8'h00);
    axis_sel = 1; #1;
    chk("R9 reset y", data, 8'h00);
    oe_n = 1; #1;
    chk("R8 idle oe", data_oe, 1'b0);
    #7 rst_x_n = 1; rst_y_n = 1;

    cyc(1, 0, 0, 0, 32'h1122_3344, 32'hA1B2_C3D4);
    cyc(1, 0, 0, 0, 32'h1122_3344, 32'hA1B2_C3D4);
    chk("R8 idle data", data, 8'h00);
    cyc(0, 0, 1, 0, 32'h5566_7788, 32'hDEAD_BEEF);
    chk("R6 R1 msb x", data, 8'h11);
    chk("R8 drive", data_oe, 1'b1);
    cyc(0, 1, 1, 0, 32'h5566_7788, 32'hDEAD_BEEF);
    chk("R2 second byte frozen", data, 8'h22);
    cyc(0, 0, 0, 0, 32'h5566_7788, 32'hDEAD_BEEF);
    chk("R3 third byte frozen", data, 8'h33);
    cyc(0, 1, 0, 1, 32'h5566_7788, 32'hDEAD_BEEF);
    chk("R7 R10 y lsb frozen", data, 8'hD4);
    cyc(0, 0, 1, 1, 32'h5566_7788, 32'hDEAD_BEEF);
    chk("R7 y msb frozen", data, 8'hA1);
    cyc(0, 1, 0, 0, 32'h5566_7788, 32'hDEAD_BEEF);
    chk("R6 x lsb frozen", data, 8'h44);
    cyc(1, 1, 0, 0, 32'h5566_7788, 32'hDEAD_BEEF);
    chk("R8 released bus", data, 8'h00);
    cyc(0, 1, 0, 0, 32'h5566_7788, 32'hDEAD_BEEF);
    chk("R4 reload after release", data, 8'h88);
    cyc(0, 1, 0, 0, 32'h0000_00F0, 32'hDEAD_BEEF);
    cyc(0, 1, 0, 0, 32'h0000_00F0, 32'hDEAD_BEEF);
    chk("R5 tracking with lsb select", data, 8'hF0);
    cyc(0, 1, 1, 1, 32'h0000_00F0, 32'h1234_5678);
    cyc(0, 1, 1, 1, 32'h0000_00F0, 32'h1234_5678);
    chk("R5 y tracking second byte", data, 8'h34);

    // R9: freeze both, reset x only
    cyc(0, 0, 1, 0, 32'h9999_9999, 32'h7777_7777);
    cyc(0, 1, 0, 0, 32'h9999_9999, 32'h7777_7777);
    chk("R9 pre-reset x frozen", data, 8'hF0);
    #1 rst_x_n = 0; #1;
    chk("R9 x cleared async", data, 8'h00);
    @(posedge clk); #1 rst_x_n = 1; #1;
    cyc(0, 1, 0, 0, 32'h9999_9999, 32'h7777_7777);
    chk("R9 x tracks after reset", data, 8'h99);
    axis_sel = 1; #1;
    chk("R9 y still frozen", data, 8'h78);
    cyc(1, 1, 0, 0, 32'h9999_9999, 32'h7777_7777);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic oe_r;
      oe_r = ($urandom_range(0, 3) == 0);
      cyc(oe_r, 1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);
      chk("R8 random oe", data_oe, !oe_r);
      chk("R6 random byte", data,
          oe_r ? 8'h00 : pick(axis_sel ? m_lat_y : m_lat_x, sel1, sel2));
      if ((i % 197) == 100) begin
        if (i % 2 == 0) rst_x_n = 0; else rst_y_n = 0;
        #1;
        chk("R9 random reset", (i % 2 == 0) ? m_lat_x : m_lat_y, 32'h0);
        @(posedge clk); #1 rst_x_n = 1; rst_y_n = 1;
      end
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule